// File: doc/BRIEF.md
# LIN Break Generator and Detector

This block adds break handling to an existing UART. On the transmit side, a one-cycle request starts a break symbol. The symbol is thirteen bit times of low level followed by one bit time of high level. While it runs, the block owns the TX line. If the UART is partway through a data frame when the request arrives, the break waits until that frame has finished. The request indication clears by itself once the high bit after the break has gone out. LIN data frames themselves carry exactly eight data bits and use the ordinary UART transmit path, which is outside this block.

On the receive side, a detector watches the synchronised RX line. It runs on its own, whether or not the normal receiver is idle or partway through a frame. The detector counts consecutive low samples, taken on an oversampling tick that runs at sixteen ticks per bit. It raises a sticky flag once the low run reaches ten bit times, or eleven when the long-length select is set. The interrupt output is the flag gated by an enable. In this mode the UART must have its synchronous clock output, multi-stop-bit, smartcard, half-duplex and infrared modes switched off; that setup belongs to the surrounding UART.

Transmit states: `TX_IDLE`, `TX_HOLD` (request waiting for the current frame), `TX_LOW` (break bits), `TX_STOP` (trailing high bit). Transitions:
- `TX_IDLE` to `TX_LOW` on a request while the transmitter is free.
- `TX_IDLE` to `TX_HOLD` on a request while a frame is busy.
- `TX_HOLD` to `TX_LOW` when the frame ends.
- `TX_LOW` to `TX_STOP` at the end of the thirteenth bit.
- `TX_STOP` to `TX_IDLE` at the end of the high bit.

Detector states: `RX_WATCH` (line high), `RX_LOW` (counting), `RX_LATCHED` (break reported, waiting for the line to go high). Transitions:
- `RX_WATCH` to `RX_LOW` on a low sample.
- `RX_LOW` to `RX_LATCHED` when the threshold is reached.
- `RX_LOW` or `RX_LATCHED` to `RX_WATCH` on any high sample.

Top module: `lin_break_unit`

## Requirements
- R1: After reset, `tx_brk_out` is 1 and `tx_brk_active`, `brk_send_busy`, `brk_flag` and `brk_irq` are all 0.
- R2: After a `brk_send_set` pulse with `tx_frame_busy` low, the block drives `tx_brk_out` low with `tx_brk_active` high for exactly 208 oversampling ticks (13 bits of 16 ticks).
- R3: The low period is followed by exactly 16 ticks of `tx_brk_out` high with `tx_brk_active` high. After that, `brk_send_busy` and `tx_brk_active` both return to 0.
- R4: A request made while `tx_frame_busy` is high sets `brk_send_busy` and leaves `tx_brk_out` high and `tx_brk_active` low until `tx_frame_busy` falls. The full break then follows.
- R5: A further `brk_send_set` pulse while a break is running has no effect: the low period stays 208 ticks.
- R6: With `brk_len_long` = 0, `brk_flag` sets once 160 consecutive tick samples of RX are low. A run of 159 or fewer low samples does not set it.
- R7: With `brk_len_long` = 1, the threshold is 176 consecutive low samples. A run of 175 does not set the flag.
- R8: A single high tick sample clears the low-time count, so two runs below the threshold separated by one high sample never set the flag.
- R9: A single low period, however long, gives only one detection. A flag cleared during that period stays clear until RX has gone high and then low again for the threshold.
- R10: `brk_flag` stays set until a `brk_flag_clr` pulse clears it. If a detection and a clear fall in the same cycle, the detection wins.
- R11: `brk_irq` is 1 exactly when `brk_flag` is 1 and `brk_ie` is 1.
- R12: Detection does not depend on the transmit side. A break the block sends, looped back to RX, sets the flag at the 11-bit length. A 9-bit low period (a zero data frame) never sets it, even while `tx_frame_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rx_in | input | 1 | Asynchronous RX line |
| tx_frame_busy | input | 1 | Normal transmitter is partway through a frame |
| brk_send_set | input | 1 | One-cycle request to send a break |
| brk_len_long | input | 1 | 0: 10-bit detect threshold, 1: 11-bit |
| brk_ie | input | 1 | Break interrupt enable |
| brk_flag_clr | input | 1 | One-cycle clear of the detected flag |
| tx_brk_out | output | 1 | TX level while a break is being sent (1 otherwise) |
| tx_brk_active | output | 1 | Block owns the TX line |
| brk_send_busy | output | 1 | Break request pending or running; self-clears |
| brk_flag | output | 1 | Sticky break-detected flag |
| brk_irq | output | 1 | Break interrupt |

## Verification
The embedded properties check these rules on every cycle:
- A detection happens only on a low sample and never in the latched state.
- A detection needs at least the short threshold of whole bits.
- The flag holds until cleared, and a clear takes effect.
- The TX line is high whenever the block is not driving it.
- A held request stays held while the frame is busy.
- The request indication drops only out of the high bit.

The exact 208 and 16 tick lengths, the 159/160 and 175/176 boundaries, the reset of the count by a one-tick glitch and the single detection per long low run can only be shown by the bench. It drives timed scenarios and compares the outputs with lengths it computes itself.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HOLD,
        TX_LOW,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_WATCH,
        RX_LOW,
        RX_LATCHED
    } rx_state_e;

endpackage

// File: rtl/lin_bit_cnt.sv
// Whole-bit counter driven by the oversampling tick.
module lin_bit_cnt #(
    parameter int TICKS_PER_BIT = 16,
    parameter int MAX_BITS      = 14,
    localparam int SW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
    localparam int BW = $clog2(MAX_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [BW-1:0] bits,
    output logic          bit_end
);

    logic [SW-1:0] sub;

    assign bit_end = step && (sub == SW'(TICKS_PER_BIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub  <= '0;
            bits <= '0;
        end else if (clr) begin
            sub  <= '0;
            bits <= '0;
        end else if (step) begin
            if (bit_end) begin
                sub <= '0;
                if (bits != BW'(MAX_BITS)) begin
                    bits <= bits + 1'b1;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    // R8: a clear empties the count on the next cycle
    p_count_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bits == '0));

endmodule

// File: rtl/lin_rx_sync.sv
// Metastability guard for the RX line; idle level is high.
module lin_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_ff
            logic [STAGES-1:0] ff;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ff <= '1;
                end else begin
                    ff[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        ff[i] <= ff[i-1];
                    end
                end
            end
            assign q = ff[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/lin_brk_tx.sv
// Break symbol sequencer: low bits then one high bit, deferred behind a busy frame.
module lin_brk_tx
    import lin_brk_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int TX_LOW_BITS   = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic send_set,
    input  logic frame_busy,
    output logic tx_out,
    output logic tx_active,
    output logic cmd_busy
);

    localparam int MAXB = TX_LOW_BITS + 1;
    localparam int BW   = $clog2(MAXB + 1);

    tx_state_e     state, nxt;
    logic [BW-1:0] bits;
    logic          bit_end;
    logic          step, clr;

    assign step = os_tick && ((state == TX_LOW) || (state == TX_STOP));
    assign clr  = (state == TX_IDLE) || (state == TX_HOLD);

    lin_bit_cnt #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .MAX_BITS     (MAXB)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .step   (step),
        .bits   (bits),
        .bit_end(bit_end)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (send_set) nxt = frame_busy ? TX_HOLD : TX_LOW;
            TX_HOLD: if (!frame_busy) nxt = TX_LOW;
            TX_LOW:  if (bit_end && (bits == BW'(TX_LOW_BITS - 1))) nxt = TX_STOP;
            TX_STOP: if (bit_end) nxt = TX_IDLE;
            default: nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        tx_out    = 1'b1;
        tx_active = 1'b0;
        cmd_busy  = 1'b0;
        unique case (state)
            TX_IDLE: begin
                tx_out = 1'b1; tx_active = 1'b0; cmd_busy = 1'b0;
            end
            TX_HOLD: begin
                tx_out = 1'b1; tx_active = 1'b0; cmd_busy = 1'b1;
            end
            TX_LOW: begin
                tx_out = 1'b0; tx_active = 1'b1; cmd_busy = 1'b1;
            end
            TX_STOP: begin
                tx_out = 1'b1; tx_active = 1'b1; cmd_busy = 1'b1;
            end
            default: begin
                tx_out = 1'b1; tx_active = 1'b0; cmd_busy = 1'b0;
            end
        endcase
    end

    // R1: the line is high whenever the block does not own it
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> tx_out);

    // R4: a held request waits while the frame is still busy
    p_hold_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_HOLD && frame_busy) |=> (state == TX_HOLD));

    // R3: the request indication drops only out of the trailing high bit
    p_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_busy) |-> $past(state == TX_STOP));

    // R2: the low phase never runs past its bit count
    p_low_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_LOW) |-> (bits < BW'(TX_LOW_BITS)));

endmodule

// File: rtl/lin_brk_rx.sv
// Independent low-time detector with sticky flag.
module lin_brk_rx
    import lin_brk_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int SHORT_BITS    = 10,
    parameter int LONG_BITS     = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rx_s,
    input  logic len_long,
    input  logic flag_clr,
    output logic flag
);

    localparam int BW = $clog2(LONG_BITS + 1);
    localparam int CW = BW + 1;

    rx_state_e     state, nxt;
    logic [BW-1:0] bits;
    logic          bit_end;
    logic          step, clr, hit;
    logic [CW-1:0] bits_after;
    logic [CW-1:0] thr;

    assign step       = os_tick && !rx_s && (state != RX_LATCHED);
    assign clr        = os_tick && rx_s;
    assign bits_after = {1'b0, bits} + CW'(1);
    assign thr        = len_long ? CW'(LONG_BITS) : CW'(SHORT_BITS);
    assign hit        = bit_end && (bits_after >= thr);

    lin_bit_cnt #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .MAX_BITS     (LONG_BITS)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .step   (step),
        .bits   (bits),
        .bit_end(bit_end)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            RX_WATCH: begin
                if (step) nxt = hit ? RX_LATCHED : RX_LOW;
            end
            RX_LOW: begin
                if (clr)      nxt = RX_WATCH;
                else if (hit) nxt = RX_LATCHED;
            end
            RX_LATCHED: begin
                if (clr) nxt = RX_WATCH;
            end
            default: nxt = RX_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_WATCH;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // R6: a detection only ever happens on a low sample
    p_hit_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !rx_s);

    // R6: a detection needs at least the short threshold of whole bits
    p_min_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (bits >= BW'(SHORT_BITS - 1)));

    // R9: no second detection before the line returns high
    p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_LATCHED) |-> !hit);

    // R10: flag is sticky without a clear
    p_flag_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R10: a clear without a coincident detection takes effect
    p_flag_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !flag);

endmodule

// File: rtl/lin_break_unit.sv
module lin_break_unit #(
    parameter int TICKS_PER_BIT = 16,
    parameter int TX_LOW_BITS   = 13,
    parameter int SHORT_BITS    = 10,
    parameter int LONG_BITS     = 11,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rx_in,
    input  logic tx_frame_busy,
    input  logic brk_send_set,
    input  logic brk_len_long,
    input  logic brk_ie,
    input  logic brk_flag_clr,
    output logic tx_brk_out,
    output logic tx_brk_active,
    output logic brk_send_busy,
    output logic brk_flag,
    output logic brk_irq
);

    logic rx_s;

    lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rx_in),
        .q    (rx_s)
    );

    lin_brk_tx #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .TX_LOW_BITS  (TX_LOW_BITS)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .send_set  (brk_send_set),
        .frame_busy(tx_frame_busy),
        .tx_out    (tx_brk_out),
        .tx_active (tx_brk_active),
        .cmd_busy  (brk_send_busy)
    );

    lin_brk_rx #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .SHORT_BITS   (SHORT_BITS),
        .LONG_BITS    (LONG_BITS)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rx_s    (rx_s),
        .len_long(brk_len_long),
        .flag_clr(brk_flag_clr),
        .flag    (brk_flag)
    );

    assign brk_irq = brk_flag && brk_ie;

endmodule

// File: tb/tb_lin_break_unit.sv
module tb_lin_break_unit;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic rx_in = 1'b1;
    logic tx_frame_busy = 1'b0;
    logic brk_send_set = 1'b0;
    logic brk_len_long = 1'b0;
    logic brk_ie = 1'b0;
    logic brk_flag_clr = 1'b0;
    logic tx_brk_out, tx_brk_active, brk_send_busy, brk_flag, brk_irq;
    logic os_tick;
    logic [1:0] ph = 2'd0;
    bit   loopback = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // tick every fourth clock, changing just after the rising edge
    always @(posedge clk) ph <= ph + 2'd1;
    assign os_tick = rst_n && (ph == 2'd3);

    lin_break_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick      (os_tick),
        .rx_in        (rx_in),
        .tx_frame_busy(tx_frame_busy),
        .brk_send_set (brk_send_set),
        .brk_len_long (brk_len_long),
        .brk_ie       (brk_ie),
        .brk_flag_clr (brk_flag_clr),
        .tx_brk_out   (tx_brk_out),
        .tx_brk_active(tx_brk_active),
        .brk_send_busy(brk_send_busy),
        .brk_flag     (brk_flag),
        .brk_irq      (brk_irq)
    );

    function automatic int exp_flag(int low_ticks, bit len_long);
        return (low_ticks >= 16 * (len_long ? 11 : 10)) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_wait(int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!os_tick);
        end
    endtask

    task automatic rx_run(int k);
        tick_wait(1);
        @(negedge clk) rx_in = 1'b0;
        tick_wait(k);
        @(negedge clk) rx_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk) brk_flag_clr = 1'b1;
        @(negedge clk) brk_flag_clr = 1'b0;
    endtask

    task automatic send_break(bit busy_pre, int busy_clks, bit again,
                              output int lows, output int highs);
        bit hold_ok = 1'b1;
        lows = 0;
        highs = 0;
        @(negedge clk);
        tx_frame_busy = busy_pre;
        brk_send_set = 1'b1;
        @(negedge clk) brk_send_set = 1'b0;
        if (busy_pre) begin
            for (int i = 0; i < busy_clks; i++) begin
                if (!brk_send_busy || tx_brk_active || !tx_brk_out) hold_ok = 1'b0;
                @(negedge clk);
            end
            chk("R4 held while frame busy", int'(hold_ok), 1);
            tx_frame_busy = 1'b0;
        end
        for (int i = 0; i < 5000; i++) begin
            brk_send_set = again && (lows == 100);
            if (loopback) rx_in = tx_brk_out;
            if (os_tick && tx_brk_active) begin
                if (!tx_brk_out) lows++;
                else             highs++;
            end
            if (!brk_send_busy) break;
            @(negedge clk);
        end
        brk_send_set = 1'b0;
        rx_in = 1'b1;
    endtask

    initial begin
        int lows, highs, k;
        bit ln;
        void'($urandom(32'd5171));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_brk_out", int'(tx_brk_out), 1);
        chk("R1 tx_brk_active", int'(tx_brk_active), 0);
        chk("R1 brk_send_busy", int'(brk_send_busy), 0);
        chk("R1 brk_flag", int'(brk_flag), 0);
        chk("R1 brk_irq", int'(brk_irq), 0);

        // R2 / R3 plain break
        send_break(1'b0, 0, 1'b0, lows, highs);
        chk("R2 low ticks", lows, 208);
        chk("R3 stop ticks", highs, 16);
        chk("R3 busy cleared", int'(brk_send_busy), 0);
        chk("R3 released", int'(tx_brk_active), 0);

        // R4 deferred behind a frame
        send_break(1'b1, 57, 1'b0, lows, highs);
        chk("R4 low ticks after hold", lows, 208);
        chk("R4 stop ticks after hold", highs, 16);

        // R5 repeated request mid-break
        send_break(1'b0, 0, 1'b1, lows, highs);
        chk("R5 low ticks unchanged", lows, 208);
        chk("R5 stop ticks unchanged", highs, 16);
        repeat (3) @(negedge clk);
        chk("R5 no extra break", int'(brk_send_busy), 0);

        // R6 boundaries
        brk_len_long = 1'b0;
        rx_run(159);
        chk("R6 159 low samples", int'(brk_flag), 0);
        rx_run(160);
        chk("R6 160 low samples", int'(brk_flag), 1);
        pulse_clr();
        chk("R10 cleared", int'(brk_flag), 0);

        // R7 boundaries
        brk_len_long = 1'b1;
        rx_run(175);
        chk("R7 175 low samples", int'(brk_flag), 0);
        rx_run(176);
        chk("R7 176 low samples", int'(brk_flag), 1);
        pulse_clr();

        // R8 one-tick glitch restarts the count
        brk_len_long = 1'b0;
        tick_wait(1);
        @(negedge clk) rx_in = 1'b0;
        tick_wait(150);
        @(negedge clk) rx_in = 1'b1;
        tick_wait(1);
        @(negedge clk) rx_in = 1'b0;
        tick_wait(150);
        @(negedge clk) rx_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 glitch resets count", int'(brk_flag), 0);

        // R9 / R10 single detection per low period
        tick_wait(1);
        @(negedge clk) rx_in = 1'b0;
        tick_wait(170);
        @(negedge clk);
        chk("R10 flag set and held", int'(brk_flag), 1);
        tick_wait(20);
        @(negedge clk);
        chk("R10 still held", int'(brk_flag), 1);
        pulse_clr();
        tick_wait(120);
        @(negedge clk);
        chk("R9 no retrigger while low", int'(brk_flag), 0);
        @(negedge clk) rx_in = 1'b1;
        repeat (3) @(negedge clk);
        rx_run(160);
        chk("R9 new low period detects", int'(brk_flag), 1);

        // R11 interrupt gating
        brk_ie = 1'b0;
        @(negedge clk);
        chk("R11 irq masked", int'(brk_irq), 0);
        brk_ie = 1'b1;
        @(negedge clk);
        chk("R11 irq enabled", int'(brk_irq), 1);
        pulse_clr();
        chk("R11 irq after clear", int'(brk_irq), 0);

        // R12 zero frame, busy transmitter, both lengths
        tx_frame_busy = 1'b1;
        brk_len_long = 1'b0;
        rx_run(144);
        chk("R12 zero frame short", int'(brk_flag), 0);
        brk_len_long = 1'b1;
        rx_run(144);
        chk("R12 zero frame long", int'(brk_flag), 0);
        tx_frame_busy = 1'b0;

        // R12 own break looped back at long length
        loopback = 1'b1;
        send_break(1'b0, 0, 1'b0, lows, highs);
        loopback = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 loopback detects", int'(brk_flag), 1);
        pulse_clr();

        // random mix: R6 R7 R11
        for (int it = 0; it < 16; it++) begin
            ln = 1'($urandom % 2);
            k = 140 + int'($urandom % 50);
            brk_len_long = ln;
            brk_ie = 1'($urandom % 2);
            tx_frame_busy = 1'($urandom % 2);
            rx_run(k);
            chk(ln ? "R7 random length" : "R6 random length",
                int'(brk_flag), exp_flag(k, ln));
            chk("R11 random irq", int'(brk_irq),
                exp_flag(k, ln) & int'(brk_ie));
            pulse_clr();
            chk("R10 random clear", int'(brk_flag), 0);
        end
        tx_frame_busy = 1'b0;

        // random deferred breaks: R2 R4
        for (int it = 0; it < 3; it++) begin
            send_break(1'($urandom % 2), 5 + int'($urandom % 80), 1'b0, lows, highs);
            chk("R2 random break low", lows, 208);
            chk("R3 random break stop", highs, 16);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule